// File: doc/BRIEF.md
# Cascade-Gated Countdown Timer

This block is a down-counting timer whose counting can be gated, triggered or stopped by three event inputs called cascades. Each cascade takes one line from a wide bundle of event lines, chosen by an 8-bit select code. By convention the bundle carries port A pins from code 0, port B pins from code 32, other timers' outputs from code 64 plus the timer index (0 to 23), the RAM single-bit and multi-bit error flags at 96 and 97, the ROM single-bit and multi-bit error flags at 98 and 99, a TX event at 100, and clock divider taps from code 120 plus the tap index (0 to 7).

Cascades 0 and 1 are start conditions. Each can be inverted, they combine by AND or OR, and each can work in trigger mode, where an edge starts a full countdown. Cascade 2 is a stop condition. It either freezes the count while it is active, or it disables the timer when it is active at the moment the count reaches zero. The timer reloads at zero and emits a one-cycle timeout pulse and an optional interrupt. Auto-disable and auto-deactivate options turn the timer into a one-shot. Software-style registers are written through plain strobes.

Top module: `casc_down_timer`

## Requirements
- R1: After reset, countOut is 0 and enableOut, activeOut, timeoutOut and irqOut are all 0.
- R2: A wrLoad strobe while enableOut is 0 writes loadValue to both the reload register and countOut on the next edge. A wrLoad strobe while enableOut is 1 changes neither.
- R3: A wrCtrl strobe sets enableOut and activeOut to ctrlEnable. While counting is allowed, the count falls by one per clock. The tick that finds the count at 0 reloads it and raises timeoutOut for one cycle, so a reload value N gives a timeout every N+1 counting cycles.
- R4: irqOut pulses together with timeoutOut when the interrupt enable, latched from ctrlIrqEn at the last wrCtrl, is 1. Otherwise irqOut stays 0.
- R5: With auto-disable set (ctrlAutoDisable at the last wrCtrl), the zero tick clears both enableOut and activeOut.
- R6: With auto-deactivate set and auto-disable clear, the zero tick clears activeOut only. enableOut stays 1 and the count holds.
- R7: cascCfg bit 0 and bit 3 make cascade 0 and cascade 1 active a condition for counting. When both are set, cascCfg bit 6 selects how they combine: 0 means AND and 1 means OR. When neither is set, counting is not gated.
- R8: cascCfg bits 1, 4 and 8 invert cascades 0, 1 and 2, making each active low.
- R9: cascCfg bits 2 and 5 put cascades 0 and 1 in trigger mode. A rising edge of the cascade after inversion counts as active from that tick until the next zero tick, whatever the input does in between.
- R10: cascCfg bit 7 set with bit 9 clear freezes the count while cascade 2 is active.
- R11: cascCfg bits 7 and 9 both set leave counting unaffected by cascade 2, except at the zero tick. If cascade 2 is active then, enableOut and activeOut are cleared.
- R12: A cascade takes line eventLines[code], where code is its select value; codes at or beyond the bundle width read as inactive. The line passes two synchronising flops, so a level set before edge E allows its first tick at edge E+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| eventLines | input | NUM_LINES | Bundle of selectable event lines |
| sel0 | input | SEL_W | Select code of cascade 0 |
| sel1 | input | SEL_W | Select code of cascade 1 |
| sel2 | input | SEL_W | Select code of cascade 2 |
| cascCfg | input | 10 | Cascade control bits (positions in R7 to R11) |
| wrCtrl | input | 1 | Write strobe for the control fields below |
| ctrlEnable | input | 1 | Enable value written by wrCtrl |
| ctrlIrqEn | input | 1 | Interrupt enable written by wrCtrl |
| ctrlAutoDisable | input | 1 | Auto-disable option written by wrCtrl |
| ctrlAutoDeactivate | input | 1 | Auto-deactivate option written by wrCtrl |
| wrLoad | input | 1 | Load strobe for reload and count |
| loadValue | input | CNT_W | Value to load |
| countOut | output | CNT_W | Current count |
| enableOut | output | 1 | Enable status |
| activeOut | output | 1 | Active status |
| timeoutOut | output | 1 | One-cycle pulse at each zero tick |
| irqOut | output | 1 | Interrupt request pulse |

## Verification
The assertions check, on every cycle, that the count falls by exactly one per cycle when the timer runs ungated, and that a hold from cascade 2 freezes it. They also check that the auto-disable and auto-deactivate options leave the status bits right after a zero tick, and that an interrupt never appears without a timeout. The bench scenarios show what a property cannot: the exact cycle of each timeout after enable or after a synchronised cascade edge, AND against OR gating, inversion, one-shot trigger behaviour, stop-at-zero, and the mapping of select codes, including codes that are out of range.

// File: rtl/casc_timer_pkg.sv
package casc_timer_pkg;
  localparam int CFG_W       = 10;
  localparam int CFG_START0  = 0;
  localparam int CFG_INV0    = 1;
  localparam int CFG_TRIG0   = 2;
  localparam int CFG_START1  = 3;
  localparam int CFG_INV1    = 4;
  localparam int CFG_TRIG1   = 5;
  localparam int CFG_DUALOR  = 6;
  localparam int CFG_STOP2   = 7;
  localparam int CFG_INV2    = 8;
  localparam int CFG_ZSTOP2  = 9;
  localparam int NUM_CASC    = 3;

  typedef struct packed {
    logic load;
    logic tick;
  } dpStrobe_t;
endpackage

// File: rtl/casc_timer_input.sv
module casc_timer_input #(
  parameter int NUM_LINES = 128,
  parameter int SEL_W     = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] eventLines,
  input  logic [SEL_W-1:0]     sel,
  input  logic                 invert,
  output logic                 lvl,
  output logic                 rise
);
  logic rawSel;
  logic syncA, syncB, lvlPrev;

  always_comb begin
    rawSel = 1'b0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (sel == SEL_W'(i)) rawSel = eventLines[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA   <= 1'b0;
      syncB   <= 1'b0;
      lvlPrev <= 1'b0;
    end else begin
      syncA   <= rawSel;
      syncB   <= syncA;
      lvlPrev <= lvl;
    end
  end

  assign lvl  = syncB ^ invert;
  assign rise = lvl & ~lvlPrev;
endmodule

// File: rtl/casc_timer_ctrl.sv
module casc_timer_ctrl
  import casc_timer_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrCtrl,
  input  logic                ctrlEnable,
  input  logic                ctrlIrqEn,
  input  logic                ctrlAutoDisable,
  input  logic                ctrlAutoDeactivate,
  input  logic                wrLoad,
  input  logic [CFG_W-1:0]    cascCfg,
  input  logic [NUM_CASC-1:0] cascLvl,
  input  logic [NUM_CASC-1:0] cascRise,
  input  logic                isZero,
  output dpStrobe_t           strb,
  output logic                enableQ,
  output logic                activeQ,
  output logic                timeoutQ,
  output logic                irqQ
);
  logic       irqEnQ, autoDisQ, autoDeactQ;
  logic [1:0] trigLatch;
  logic [1:0] startEn, trigMode, effStart;
  logic       startOk, holdNow, stopAtZero, countEn, zeroTick;

  assign startEn  = {cascCfg[CFG_START1], cascCfg[CFG_START0]};
  assign trigMode = {cascCfg[CFG_TRIG1], cascCfg[CFG_TRIG0]};

  for (genvar k = 0; k < 2; k++) begin : g_start
    assign effStart[k] = trigMode[k] ? (trigLatch[k] | cascRise[k]) : cascLvl[k];
  end

  always_comb begin
    unique case (startEn)
      2'b00:   startOk = 1'b1;
      2'b01:   startOk = effStart[0];
      2'b10:   startOk = effStart[1];
      default: startOk = cascCfg[CFG_DUALOR] ? (effStart[0] | effStart[1])
                                             : (effStart[0] & effStart[1]);
    endcase
  end

  assign holdNow    = cascCfg[CFG_STOP2] & ~cascCfg[CFG_ZSTOP2] & cascLvl[2];
  assign stopAtZero = cascCfg[CFG_STOP2] &  cascCfg[CFG_ZSTOP2] & cascLvl[2];
  assign countEn    = enableQ & activeQ & startOk & ~holdNow;
  assign zeroTick   = countEn & isZero;

  assign strb.load = wrLoad & ~enableQ;
  assign strb.tick = countEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ    <= 1'b0;
      activeQ    <= 1'b0;
      irqEnQ     <= 1'b0;
      autoDisQ   <= 1'b0;
      autoDeactQ <= 1'b0;
      trigLatch  <= '0;
    end else if (wrCtrl) begin
      enableQ    <= ctrlEnable;
      activeQ    <= ctrlEnable;
      irqEnQ     <= ctrlIrqEn;
      autoDisQ   <= ctrlAutoDisable;
      autoDeactQ <= ctrlAutoDeactivate;
      trigLatch  <= '0;
    end else if (zeroTick) begin
      trigLatch <= '0;
      if (autoDisQ || stopAtZero) begin
        enableQ <= 1'b0;
        activeQ <= 1'b0;
      end else if (autoDeactQ) begin
        activeQ <= 1'b0;
      end
    end else if (enableQ && activeQ) begin
      trigLatch <= trigLatch | (cascRise[1:0] & trigMode);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timeoutQ <= 1'b0;
      irqQ     <= 1'b0;
    end else begin
      timeoutQ <= zeroTick;
      irqQ     <= zeroTick & irqEnQ;
    end
  end

  // R5: auto-disable drops both status bits after the zero tick
  p_autodis_r5: assert property (@(posedge clk) disable iff (!rstN)
    (zeroTick && autoDisQ && !wrCtrl) |=> (!enableQ && !activeQ));

  // R6: auto-deactivate keeps the enable bit and drops the active bit
  p_deact_r6: assert property (@(posedge clk) disable iff (!rstN)
    (zeroTick && autoDeactQ && !autoDisQ && !stopAtZero && !wrCtrl) |=> (enableQ && !activeQ));

  // R11: stop-at-zero with cascade 2 active disables the timer
  p_zstop_r11: assert property (@(posedge clk) disable iff (!rstN)
    (zeroTick && stopAtZero && !wrCtrl) |=> (!enableQ && !activeQ));
endmodule

// File: rtl/casc_timer_dp.sv
module casc_timer_dp
  import casc_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic [CNT_W-1:0] loadValue,
  output logic [CNT_W-1:0] countQ,
  output logic             isZero
);
  logic [CNT_W-1:0] reloadQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadQ <= '0;
      countQ  <= '0;
    end else if (strb.load) begin
      reloadQ <= loadValue;
      countQ  <= loadValue;
    end else if (strb.tick) begin
      countQ <= isZero ? reloadQ : countQ - CNT_W'(1);
    end
  end

  assign isZero = (countQ == '0);
endmodule

// File: rtl/casc_down_timer.sv
module casc_down_timer
  import casc_timer_pkg::*;
#(
  parameter int NUM_LINES = 128,
  parameter int SEL_W     = 8,
  parameter int CNT_W     = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] eventLines,
  input  logic [SEL_W-1:0]     sel0,
  input  logic [SEL_W-1:0]     sel1,
  input  logic [SEL_W-1:0]     sel2,
  input  logic [9:0]           cascCfg,
  input  logic                 wrCtrl,
  input  logic                 ctrlEnable,
  input  logic                 ctrlIrqEn,
  input  logic                 ctrlAutoDisable,
  input  logic                 ctrlAutoDeactivate,
  input  logic                 wrLoad,
  input  logic [CNT_W-1:0]     loadValue,
  output logic [CNT_W-1:0]     countOut,
  output logic                 enableOut,
  output logic                 activeOut,
  output logic                 timeoutOut,
  output logic                 irqOut
);
  logic [SEL_W-1:0]    selArr [NUM_CASC];
  logic [NUM_CASC-1:0] invArr, cascLvl, cascRise;
  dpStrobe_t           strb;
  logic                isZero;

  assign selArr[0] = sel0;
  assign selArr[1] = sel1;
  assign selArr[2] = sel2;
  assign invArr    = {cascCfg[CFG_INV2], cascCfg[CFG_INV1], cascCfg[CFG_INV0]};

  for (genvar k = 0; k < NUM_CASC; k++) begin : g_casc
    casc_timer_input #(.NUM_LINES(NUM_LINES), .SEL_W(SEL_W)) u_in (
      .clk(clk), .rstN(rstN), .eventLines(eventLines), .sel(selArr[k]),
      .invert(invArr[k]), .lvl(cascLvl[k]), .rise(cascRise[k])
    );
  end

  casc_timer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrCtrl(wrCtrl), .ctrlEnable(ctrlEnable),
    .ctrlIrqEn(ctrlIrqEn), .ctrlAutoDisable(ctrlAutoDisable),
    .ctrlAutoDeactivate(ctrlAutoDeactivate), .wrLoad(wrLoad), .cascCfg(cascCfg),
    .cascLvl(cascLvl), .cascRise(cascRise), .isZero(isZero), .strb(strb),
    .enableQ(enableOut), .activeQ(activeOut), .timeoutQ(timeoutOut), .irqQ(irqOut)
  );

  casc_timer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .loadValue(loadValue),
    .countQ(countOut), .isZero(isZero)
  );

  // R3: ungated running timer counts down by one per cycle
  p_dec_r3: assert property (@(posedge clk) disable iff (!rstN)
    (enableOut && activeOut && !cascCfg[CFG_START0] && !cascCfg[CFG_START1] &&
     !cascCfg[CFG_STOP2] && countOut != '0 && !wrCtrl)
    |=> (countOut == $past(countOut) - CNT_W'(1)));

  // R10: cascade 2 hold freezes the count
  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cascCfg[CFG_STOP2] && !cascCfg[CFG_ZSTOP2] && cascLvl[2] && !wrLoad)
    |=> $stable(countOut));

  // R4: an interrupt only comes with a timeout
  p_irq_with_timeout_r4: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> timeoutOut);
endmodule

// File: tb/casc_down_timer_tb.sv
`timescale 1ns/1ps
module casc_down_timer_tb;
  localparam int NL = 128;
  localparam int SW = 8;
  localparam int CW = 16;

  logic clk = 0;
  logic rstN = 0;
  logic [NL-1:0] eventLines = '0;
  logic [SW-1:0] sel0 = '0, sel1 = '0, sel2 = '0;
  logic [9:0] cascCfg = '0;
  logic wrCtrl = 0, ctrlEnable = 0, ctrlIrqEn = 0, ctrlAutoDisable = 0, ctrlAutoDeactivate = 0;
  logic wrLoad = 0;
  logic [CW-1:0] loadValue = '0;
  logic [CW-1:0] countOut;
  logic enableOut, activeOut, timeoutOut, irqOut;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  int expCyc[$];
  bit expIrq[$];

  casc_down_timer #(.NUM_LINES(NL), .SEL_W(SW), .CNT_W(CW)) u_dut (
    .clk(clk), .rstN(rstN), .eventLines(eventLines), .sel0(sel0), .sel1(sel1),
    .sel2(sel2), .cascCfg(cascCfg), .wrCtrl(wrCtrl), .ctrlEnable(ctrlEnable),
    .ctrlIrqEn(ctrlIrqEn), .ctrlAutoDisable(ctrlAutoDisable),
    .ctrlAutoDeactivate(ctrlAutoDeactivate), .wrLoad(wrLoad), .loadValue(loadValue),
    .countOut(countOut), .enableOut(enableOut), .activeOut(activeOut),
    .timeoutOut(timeoutOut), .irqOut(irqOut)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor: each timeout pulse must match the next expected item
  always @(negedge clk) begin
    if (rstN && timeoutOut) begin
      if (expCyc.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R3 unexpected timeout: actual cycle %0d expected none", cyc);
      end else begin
        chk("R3 timeout cycle", cyc, expCyc.pop_front());
        chk("R4 irq with timeout", int'(irqOut), int'(expIrq.pop_front()));
      end
    end
  end

  task automatic expectTo(int c, bit irq);
    expCyc.push_back(c);
    expIrq.push_back(irq);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitUntil(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic writeCtrl(bit en, bit irq, bit ad, bit adq, output int c0);
    @(negedge clk);
    wrCtrl = 1; ctrlEnable = en; ctrlIrqEn = irq;
    ctrlAutoDisable = ad; ctrlAutoDeactivate = adq;
    @(posedge clk); #1 c0 = cyc;
    @(negedge clk);
    wrCtrl = 0;
  endtask

  task automatic loadVal(int v);
    @(negedge clk);
    wrLoad = 1; loadValue = CW'(v);
    @(negedge clk);
    wrLoad = 0;
  endtask

  task automatic setLine(int idx, bit v, output int e);
    @(negedge clk);
    eventLines[idx] = v;
    @(posedge clk); #1 e = cyc;
  endtask

  task automatic slope(string tag, int expDelta);
    int a;
    a = int'(countOut);
    tick(4);
    chk(tag, a - int'(countOut), expDelta);
  endtask

  initial begin
    int c0, e, dummy;
    tick(4);
    rstN = 1;
    chk("R1 count", int'(countOut), 0);
    chk("R1 enable", int'(enableOut), 0);
    chk("R1 active", int'(activeOut), 0);
    chk("R1 timeout", int'(timeoutOut), 0);
    chk("R1 irq", int'(irqOut), 0);

    // level gate on cascade 0 (code 10), load behaviour
    cascCfg = 10'd1; sel0 = 8'd10;
    loadVal(5);
    chk("R2 load when disabled", int'(countOut), 5);
    writeCtrl(1, 0, 0, 1, c0);
    tick(4);
    chk("R7 gate inactive holds", int'(countOut), 5);
    loadVal(9);
    tick(1);
    chk("R2 load ignored when enabled", int'(countOut), 5);
    setLine(10, 1, e);
    expectTo(e + 7, 0);            // R12 sync latency: first tick at e+2
    waitUntil(e + 9);
    chk("R6 enable kept", int'(enableOut), 1);
    chk("R6 active cleared", int'(activeOut), 0);
    chk("R6 count holds at reload", int'(countOut), 5);
    setLine(10, 0, dummy);
    writeCtrl(0, 0, 0, 0, c0);

    // free running with interrupt
    cascCfg = '0;
    loadVal(5);
    writeCtrl(1, 1, 0, 0, c0);
    expectTo(c0 + 6, 1);
    expectTo(c0 + 12, 1);
    waitUntil(c0 + 2);
    chk("R3 count after two ticks", int'(countOut), 3);
    waitUntil(c0 + 13);
    writeCtrl(0, 0, 0, 0, c0);
    chk("R3 disable write", int'(enableOut), 0);

    // auto-disable
    loadVal(3);
    writeCtrl(1, 0, 1, 0, c0);
    expectTo(c0 + 4, 0);
    waitUntil(c0 + 6);
    chk("R5 enable cleared", int'(enableOut), 0);
    chk("R5 active cleared", int'(activeOut), 0);
    chk("R5 count reloaded", int'(countOut), 3);

    // AND / OR combination of cascades 0 and 1
    loadVal(50);
    cascCfg = 10'd9; sel0 = 8'd10; sel1 = 8'd11;
    writeCtrl(1, 0, 0, 0, c0);
    setLine(10, 1, dummy);
    tick(3);
    slope("R7 AND one active", 0);
    setLine(11, 1, dummy);
    tick(3);
    slope("R7 AND both active", 4);
    cascCfg = 10'd73;
    setLine(10, 0, dummy);
    tick(3);
    slope("R7 OR one active", 4);
    setLine(11, 0, dummy);
    tick(3);
    slope("R7 OR none active", 0);

    // inversion of cascade 0
    cascCfg = 10'd3;
    tick(3);
    slope("R8 inverted low counts", 4);
    setLine(10, 1, dummy);
    tick(3);
    slope("R8 inverted high holds", 0);
    writeCtrl(0, 0, 0, 0, c0);
    setLine(10, 0, dummy);

    // trigger mode on cascade 0 (code 12)
    cascCfg = 10'd5; sel0 = 8'd12;
    loadVal(4);
    writeCtrl(1, 0, 0, 0, c0);
    tick(3);
    chk("R9 waits for edge", int'(countOut), 4);
    setLine(12, 1, e);
    setLine(12, 0, dummy);
    expectTo(e + 6, 0);
    waitUntil(e + 9);
    chk("R9 holds after one shot", int'(countOut), 4);
    chk("R9 stays enabled", int'(enableOut), 1);
    writeCtrl(0, 0, 0, 0, c0);

    // cascade 2 hold, select codes (timer 3 = 67)
    cascCfg = 10'd128; sel2 = 8'd67;
    loadVal(50);
    writeCtrl(1, 0, 0, 0, c0);
    tick(3);
    slope("R10 no hold counts", 4);
    setLine(68, 1, dummy);
    tick(3);
    slope("R12 other line no effect", 4);
    setLine(67, 1, dummy);
    tick(3);
    slope("R10 hold freezes", 0);
    setLine(67, 0, dummy);
    setLine(68, 0, dummy);
    sel2 = 8'd200;
    @(negedge clk) eventLines = '1;
    tick(3);
    slope("R12 out of range code inactive", 4);
    @(negedge clk) eventLines = '0;
    writeCtrl(0, 0, 0, 0, c0);

    // stop at zero on cascade 2 (TX event = 100)
    cascCfg = 10'd640; sel2 = 8'd100;
    setLine(100, 1, dummy);
    loadVal(3);
    writeCtrl(1, 0, 0, 0, c0);
    expectTo(c0 + 4, 0);
    waitUntil(c0 + 6);
    chk("R11 disabled at zero", int'(enableOut), 0);
    chk("R11 inactive at zero", int'(activeOut), 0);
    setLine(100, 0, dummy);
    tick(3);
    writeCtrl(1, 0, 0, 0, c0);
    expectTo(c0 + 4, 0);
    expectTo(c0 + 8, 0);
    waitUntil(c0 + 9);
    chk("R11 inactive cascade keeps running", int'(enableOut), 1);
    writeCtrl(0, 0, 0, 0, c0);

    tick(5);
    chk("R3 all timeouts seen", expCyc.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule